// File: doc/BRIEF.md
# Ethernet Frame Test Generator

This block produces a continuous stream of complete IEEE 802.3 frames, one byte per accepted transfer, for a traffic test rig. Two board switches pick one of four preset payload lengths. Each frame is laid out as preamble, start-of-frame delimiter, destination and source addresses, a length field, pseudo-random payload bytes, zero padding up to the minimum payload size, and a CRC-32 frame check sequence. A fixed idle gap separates consecutive frames.

The byte stream leaves on a valid/ready interface. A byte is transferred on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the block holds the byte and both frame markers unchanged, and it does not withdraw `out_valid` until the byte has been taken. The sink may stall for any number of cycles, anywhere in a frame. The idle gap is measured in clock cycles and does not depend on `out_ready`. Payload bytes come from an internal LFSR that is seeded at reset, so a checker that knows the seed can predict every frame.

Top module: `eth_frame_gen`

## Requirements
- R1: The switch value `len_sel` is sampled once, in the cycle a frame begins. Value 0 selects LEN0 (60), 1 selects LEN1 (0), 2 selects LEN2 (45) and 3 selects LEN3 (1500). The frame then carries exactly that many payload bytes.
- R2: Every frame opens with 7 bytes of 0x55 and then one byte of 0xD5. `out_sof` is high only on the first 0x55 byte. `out_sof` and `out_eof` are never high together.
- R3: After the delimiter come the 6 destination address bytes (default 02_00_5E_10_20_30) and then the 6 source address bytes (default 02_AA_BB_CC_DD_EE), each address most significant byte first. Next comes a 2-byte field holding the selected payload length, high byte first.
- R4: Each payload byte is bits [7:0] of a 32-bit LFSR. The LFSR steps once per accepted payload byte as follows: shift right by one, then XOR with 0x80200003 if the bit shifted out was 1. Reset loads the seed 0xC0FFEE01. The LFSR is never reloaded between frames.
- R5: When the selected length is below 46, zero bytes follow the payload until payload plus pad totals 46. With a length of 46 or more there is no pad.
- R6: The frame ends with 4 bytes holding the inverted reflected CRC-32 (polynomial 0x04C11DB7, start value 0xFFFFFFFF), computed over the bytes from the destination address through the pad. The bytes are sent least significant byte first, and `out_eof` is high on the last one.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle shows `out_valid` high with the same `out_data`, `out_sof` and `out_eof`.
- R8: After the last frame byte is accepted, `out_valid` stays low for exactly 12 cycles before the next preamble. After reset is released, the same 12 idle cycles come before the first preamble.
- R9: A change of `len_sel` in the middle of a frame does not change the length field, the payload count or the pad of that frame.
- R10: While reset is asserted, `out_valid`, `out_sof` and `out_eof` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_sel | input | 2 | Switch selection of payload length preset |
| out_ready | input | 1 | Sink accepts the current byte |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_sof | output | 1 | First preamble byte of a frame |
| out_eof | output | 1 | Last check-sequence byte of a frame |

## Verification
The assertions check stream behaviour on every cycle. They cover the hold of data and markers under stall, idle after the end marker, a start marker always landing on a preamble byte after a full idle gap, the length held for the whole frame, the payload index bounded by that length, and the LFSR never reaching zero. Byte contents can only be shown by the bench's scenarios, which compare whole captured frames against frames predicted from the seed and the selected length. This covers the address and length fields, the LFSR payload carried across frames, the pad, and the CRC. The scenarios also show that a length switched mid-frame leaves the current frame intact and that each of the four presets, including zero and the 1500-byte maximum, produces the right byte count.

// File: rtl/eth_gen_pkg.sv
package eth_gen_pkg;

  typedef enum logic [3:0] {
    FLD_GAP, FLD_PRE, FLD_SFD, FLD_DST, FLD_SRC,
    FLD_LEN, FLD_PAY, FLD_PAD, FLD_FCS
  } fld_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte of reflected CRC-32 update
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_lfsr.sv
module eth_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] SEED = 32'hC0FFEE01,
  parameter logic [W-1:0] TAP_MASK = 32'h80200003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (step) begin
      state <= state[0] ? ((state >> 1) ^ TAP_MASK) : (state >> 1);
    end
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R4

endmodule

// File: rtl/eth_crc32.sv
module eth_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import eth_gen_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '1;
    end else if (clear) begin
      crc <= '1;
    end else if (en) begin
      crc <= crc32_step(crc, din);
    end
  end

endmodule

// File: rtl/eth_frame_seq.sv
module eth_frame_seq
  import eth_gen_pkg::*;
#(
  parameter int LEN0 = 60,
  parameter int LEN1 = 0,
  parameter int LEN2 = 45,
  parameter int LEN3 = 1500,
  parameter int PRE_LEN = 7,
  parameter int ADDR_BYTES = 6,
  parameter int MIN_PAY = 46,
  parameter int GAP_CYCLES = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    len_sel,
  input  logic          accept,
  output fld_e          fld,
  output logic [CW-1:0] idx,
  output logic [CW-1:0] len_q
);

  logic [CW-1:0] pad_q;
  logic [CW-1:0] pick_len;
  logic [CW-1:0] pick_pad;
  logic          last;
  fld_e          nxt;

  always_comb begin
    case (len_sel)
      2'd0:    pick_len = CW'(LEN0);
      2'd1:    pick_len = CW'(LEN1);
      2'd2:    pick_len = CW'(LEN2);
      default: pick_len = CW'(LEN3);
    endcase
    pick_pad = (pick_len < CW'(MIN_PAY)) ? (CW'(MIN_PAY) - pick_len) : '0;
  end

  // End-of-field detection and successor field
  always_comb begin
    last = 1'b0;
    nxt  = FLD_GAP;
    case (fld)
      FLD_PRE: begin last = (idx == CW'(PRE_LEN - 1));    nxt = FLD_SFD; end
      FLD_SFD: begin last = 1'b1;                          nxt = FLD_DST; end
      FLD_DST: begin last = (idx == CW'(ADDR_BYTES - 1)); nxt = FLD_SRC; end
      FLD_SRC: begin last = (idx == CW'(ADDR_BYTES - 1)); nxt = FLD_LEN; end
      FLD_LEN: begin
        last = (idx == CW'(1));
        if (len_q != '0)      nxt = FLD_PAY;
        else if (pad_q != '0) nxt = FLD_PAD;
        else                  nxt = FLD_FCS;
      end
      FLD_PAY: begin
        last = (idx == len_q - CW'(1));
        nxt  = (pad_q != '0) ? FLD_PAD : FLD_FCS;
      end
      FLD_PAD: begin last = (idx == pad_q - CW'(1)); nxt = FLD_FCS; end
      FLD_FCS: begin last = (idx == CW'(3));         nxt = FLD_GAP; end
      default: begin last = 1'b0;                    nxt = FLD_GAP; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld   <= FLD_GAP;
      idx   <= '0;
      len_q <= '0;
      pad_q <= '0;
    end else if (fld == FLD_GAP) begin
      if (idx == CW'(GAP_CYCLES - 1)) begin
        fld   <= FLD_PRE;
        idx   <= '0;
        len_q <= pick_len;
        pad_q <= pick_pad;
      end else begin
        idx <= idx + CW'(1);
      end
    end else if (accept) begin
      if (last) begin
        fld <= nxt;
        idx <= '0;
      end else begin
        idx <= idx + CW'(1);
      end
    end
  end

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fld != FLD_GAP) |=> $stable(len_q)); // R9

  AST_PAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (fld == FLD_PAY) |-> (idx < len_q)); // R4

endmodule

// File: rtl/eth_frame_gen.sv
module eth_frame_gen
  import eth_gen_pkg::*;
#(
  parameter int LEN0 = 60,
  parameter int LEN1 = 0,
  parameter int LEN2 = 45,
  parameter int LEN3 = 1500,
  parameter logic [47:0] DST_MAC = 48'h02005E102030,
  parameter logic [47:0] SRC_MAC = 48'h02AABBCCDDEE,
  parameter logic [31:0] LFSR_SEED = 32'hC0FFEE01,
  parameter int PRE_LEN = 7,
  parameter int MIN_PAY = 46,
  parameter int GAP_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] len_sel,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof
);

  localparam int CW = 16;
  localparam int ADDR_BYTES = 6;
  localparam logic [31:0] LFSR_MASK = 32'h80200003;
  localparam int IW = $clog2(GAP_CYCLES + 1);

  fld_e          fld;
  logic [CW-1:0] idx;
  logic [CW-1:0] len_q;
  logic [31:0]   lfsr;
  logic [31:0]   crc;
  logic          accept;
  logic [5:0]    sh_addr;
  logic [47:0]   dst_word;
  logic [47:0]   src_word;
  logic [31:0]   fcs_word;

  eth_frame_seq #(
    .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3),
    .PRE_LEN(PRE_LEN), .ADDR_BYTES(ADDR_BYTES), .MIN_PAY(MIN_PAY),
    .GAP_CYCLES(GAP_CYCLES), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .accept(accept),
    .fld(fld), .idx(idx), .len_q(len_q)
  );

  eth_lfsr #(.W(32), .SEED(LFSR_SEED), .TAP_MASK(LFSR_MASK)) u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .step(accept && (fld == FLD_PAY)),
    .state(lfsr)
  );

  eth_crc32 u_crc (
    .clk(clk), .rst_n(rst_n),
    .clear(fld == FLD_GAP),
    .en(accept && (fld inside {FLD_DST, FLD_SRC, FLD_LEN, FLD_PAY, FLD_PAD})),
    .din(out_data),
    .crc(crc)
  );

  assign out_valid = (fld != FLD_GAP);
  assign accept    = out_valid && out_ready;
  assign out_sof   = (fld == FLD_PRE) && (idx == '0);
  assign out_eof   = (fld == FLD_FCS) && (idx == CW'(3));

  always_comb begin
    sh_addr  = 6'((ADDR_BYTES - 1 - int'(idx[2:0])) * 8);
    dst_word = DST_MAC >> sh_addr;
    src_word = SRC_MAC >> sh_addr;
    fcs_word = (~crc) >> {idx[1:0], 3'b000};
    case (fld)
      FLD_PRE: out_data = 8'h55;
      FLD_SFD: out_data = 8'hD5;
      FLD_DST: out_data = dst_word[7:0];
      FLD_SRC: out_data = src_word[7:0];
      FLD_LEN: out_data = (idx == '0) ? len_q[15:8] : len_q[7:0];
      FLD_PAY: out_data = lfsr[7:0];
      FLD_FCS: out_data = fcs_word[7:0];
      default: out_data = 8'h00;
    endcase
  end

  // Idle run length, kept only for the gap check below
  logic [IW-1:0] idle_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run <= '0;
    end else if (out_valid) begin
      idle_run <= '0;
    end else if (idle_run != IW'(GAP_CYCLES)) begin
      idle_run <= idle_run + IW'(1);
    end
  end

  AST_SOF_ON_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && out_data == 8'h55)); // R2

  AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sof && out_eof)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R7

  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> !out_valid); // R8

  AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && idle_run != '0) |-> (idle_run >= IW'(GAP_CYCLES))); // R8

endmodule

// File: tb/eth_frame_gen_test.sv
module eth_frame_gen_test;

  localparam int GAP = 12;
  localparam int N_FRAMES = 14;
  localparam int MAX_CYC = 150000;
  localparam logic [47:0] M_DST = 48'h02005E102030;
  localparam logic [47:0] M_SRC = 48'h02AABBCCDDEE;
  localparam logic [31:0] M_SEED = 32'hC0FFEE01;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] len_sel;
  logic       out_ready;
  logic [7:0] out_data;
  logic       out_valid, out_sof, out_eof;

  always #5 clk = ~clk;

  eth_frame_gen uut (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_lfsr;
  logic [7:0] rx[$];
  logic [7:0] ex[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input int s);
    case (s)
      0: return 60;
      1: return 0;
      2: return 45;
      default: return 1500;
    endcase
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  task automatic build_expected(input int s);
    int L;
    logic [31:0] c;
    L = len_of(s);
    ex.delete();
    for (int i = 0; i < 7; i++) ex.push_back(8'h55);
    ex.push_back(8'hD5);
    for (int i = 5; i >= 0; i--) ex.push_back(M_DST[i*8 +: 8]);
    for (int i = 5; i >= 0; i--) ex.push_back(M_SRC[i*8 +: 8]);
    ex.push_back(8'(L >> 8));
    ex.push_back(8'(L));
    for (int i = 0; i < L; i++) begin
      ex.push_back(m_lfsr[7:0]);
      m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'h80200003) : (m_lfsr >> 1);
    end
    for (int i = L; i < 46; i++) ex.push_back(8'h00);
    c = 32'hFFFFFFFF;
    for (int i = 8; i < ex.size(); i++) c = crc_byte(c, ex[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) ex.push_back(c[i*8 +: 8]);
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req, input string what);
    bit ok = 1'b1;
    int at = lo;
    for (int i = lo; i < hi; i++) begin
      if (ok && rx[i] !== ex[i]) begin ok = 1'b0; at = i; end
    end
    if (ok || hi <= lo) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, $sformatf("%s byte %0d", what, at), longint'(rx[at]), longint'(ex[at]));
  endtask

  task automatic check_frame(input int s, input bit changed);
    int L, P;
    L = len_of(s);
    P = (L < 46) ? 46 - L : 0;
    build_expected(s);
    check(rx.size() == ex.size(), "R1", $sformatf("frame size sel %0d", s), rx.size(), ex.size());
    if (changed)
      check(rx.size() == ex.size(), "R9", "size after mid-frame switch", rx.size(), ex.size());
    if (rx.size() == ex.size()) begin
      cmp_range(0, 8, "R2", "preamble/delimiter");
      cmp_range(8, 22, "R3", "addresses/length field");
      cmp_range(22, 22 + L, "R4", "payload");
      cmp_range(22 + L, 22 + L + P, "R5", "pad");
      cmp_range(22 + L + P, ex.size(), "R6", "check sequence");
    end
  endtask

  initial begin
    bit in_frame = 1'b0;
    bit changed = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_sof = 1'b0, prev_eof = 1'b0;
    int low_run = 0;
    int cur_sel = 0;
    int frames = 0;
    logic [1:0] prev_sel;
    int seen_sel[4];
    void'($urandom(32'd20240611));
    foreach (seen_sel[k]) seen_sel[k] = 0;
    rst_n = 1'b0;
    out_ready = 1'b0;
    len_sel = 2'd0;
    m_lfsr = M_SEED;
    repeat (3) begin
      @(negedge clk);
      out_ready = ~out_ready;
      #1;
      check(!out_valid && !out_sof && !out_eof, "R10", "outputs in reset",
            {out_valid, out_sof, out_eof}, 0);
    end
    for (int cyc = 0; cyc < MAX_CYC && frames < N_FRAMES; cyc++) begin
      @(negedge clk);
      if (cyc == 0) rst_n = 1'b1;
      prev_sel = len_sel;
      if (frames < 4) begin
        out_ready = 1'b1;
        len_sel = 2'(frames);
      end else begin
        out_ready = ($urandom % 4) != 0;
        if (($urandom % 16) == 0) len_sel = 2'($urandom % 4);
      end
      #1;
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_sof == prev_sof && out_eof == prev_eof,
              "R7", "held byte under stall", {out_valid, out_data}, {1'b1, prev_data});
      if (out_valid) begin
        if (out_sof && !in_frame) begin
          check(low_run == GAP, "R8", "idle cycles before frame", low_run, GAP);
          in_frame = 1'b1;
          cur_sel = int'(prev_sel);
          changed = 1'b0;
          rx.delete();
        end
        if (in_frame && int'(len_sel) != cur_sel) changed = 1'b1;
        if (out_ready) begin
          rx.push_back(out_data);
          if (out_eof) begin
            check_frame(cur_sel, changed);
            seen_sel[cur_sel]++;
            frames++;
            in_frame = 1'b0;
            low_run = 0;
          end
        end
      end else begin
        low_run++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_sof = out_sof;
      prev_eof = out_eof;
    end
    if (frames < N_FRAMES)
      check(1'b0, "WATCHDOG", "frames completed", frames, N_FRAMES);
    for (int k = 0; k < 4; k++)
      check(seen_sel[k] != 0, "R1", $sformatf("preset %0d exercised", k), seen_sel[k], 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule